// File: doc/BRIEF.md
# Doorbell Mailbox Console Bridge

This block carries a byte-wide console between a host bus and a local processor. Each direction has a 32-bit mailbox and a doorbell register. A character is posted into a mailbox with its top bit set, and then a typed code is rung on the doorbell. The host reaches all four registers through a simple register port. The local side sees only a transmit byte stream, a receive byte stream, an interrupt and two status outputs. A small hardware engine does all the local protocol work.

The engine handles three things. It answers liveness pings. It resets the receive ring when the host opens a session. It copies incoming console characters into a receive ring. Flow control works through the receive mailbox itself. While the ring still has room, the engine empties the mailbox as soon as it has taken the character. When the ring is nearly full, the engine leaves the mailbox occupied, so the host cannot post another character. The engine clears the mailbox again once the local reader has drained the ring below the mark. On the transmit side, the engine waits for an empty outgoing mailbox before it posts each character. Every line feed is followed automatically by a carriage return.

Top module: `dbmb_console`

## Requirements
- R1: After reset all four host-visible registers read zero, `txReady` is 1, and `rxValid`, `hostIrq`, `localIrq`, `linkUp` and `badCode` are 0.
- R2: A byte accepted on the transmit stream is written into the outgoing mailbox (host address 1) as `0x8000_0000 | byte` on the second clock edge after acceptance, provided that mailbox reads zero. On the same edge, code 0x5 is OR-ed into the host-side doorbell (host address 3). While the mailbox is non-zero, the byte is held back and the mailbox is left unchanged.
- R3: When the transmitted byte is 0x0A, the block sends 0x0D as the very next transmitted character, using the same mailbox rule. `txReady` stays low until the 0x0D has been posted.
- R4: An incoming doorbell value of 0x1 (liveness) makes the block OR 0x1 into the host-side doorbell.
- R5: An incoming doorbell value of 0x2 (open session) empties the receive ring, clears the full condition, zeroes the incoming mailbox (host address 0) and sets `linkUp`.
- R6: An incoming doorbell value of 0x5 (console data) stores bits 7:0 of the incoming mailbox into a ring of `DEPTH` (256) entries. The stored bytes come out on `rxChar`/`rxValid` in arrival order and are popped by `rxReady`.
- R7: After storing a byte, the block zeroes the incoming mailbox only if the ring then holds at most `DEPTH-4` entries. Otherwise it sets the full condition and leaves the mailbox as written.
- R8: While the full condition holds, a pop that leaves fewer than `DEPTH-4` entries clears the condition and zeroes the incoming mailbox. A pop that leaves exactly `DEPTH-4` entries changes nothing.
- R9: Host writes to address 2 set bits in the incoming doorbell, and host writes to address 3 clear bits in the host-side doorbell (write one to clear). The engine handles a pending incoming doorbell on the next edge and clears exactly the bits it handled.
- R10: An incoming doorbell value that is none of 0x1, 0x2, 0x3 and 0x5 sets the sticky output `badCode`. It has no other effect: no ring write, no mailbox change and no outgoing doorbell.
- R11: `localIrq` is the OR of the incoming doorbell bits under `LOCAL_IRQ_MASK`, and `hostIrq` is the OR of the host-side doorbell bits under `HOST_IRQ_MASK`.
- R12: A pulse on `dropLink` ORs code 0x3 into the host-side doorbell and clears `linkUp`. An incoming doorbell value of 0x3 also clears `linkUp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 2 | Host register select: 0 incoming mailbox, 1 outgoing mailbox, 2 incoming doorbell, 3 host-side doorbell |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data for the register selected by `hostAddr` (combinational) |
| hostIrq | output | 1 | Interrupt toward the host |
| txValid | input | 1 | Local transmit byte valid |
| txChar | input | 8 | Local transmit byte |
| txReady | output | 1 | Transmit path can accept a byte |
| rxValid | output | 1 | Receive ring holds at least one byte |
| rxChar | output | 8 | Oldest byte in the receive ring |
| rxReady | input | 1 | Pops the receive byte when `rxValid` is high |
| dropLink | input | 1 | Local request to end the session |
| localIrq | output | 1 | Interrupt toward the local side |
| linkUp | output | 1 | Session is open |
| badCode | output | 1 | Sticky flag: an unknown doorbell code was seen |

## Verification
The assertions assume that the host follows the mailbox protocol. The host writes the incoming mailbox only when it reads zero, it never zeroes that mailbox while the ring reports full, and it writes only zero to the outgoing mailbox. The host-side doorbell interrupt check is valid only with the default all-ones host mask. The stimulus keeps to these rules. It always drives a host write as a single isolated cycle. It rings a doorbell only after the mailbox data is in place. It clears the outgoing mailbox only after reading a non-zero value from it. It never writes the incoming mailbox while a data code is still pending.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int MBOX_W = 32;
  localparam int CHAR_W = 8;

  localparam logic [MBOX_W-1:0] CODE_ALIVE      = 32'h1;
  localparam logic [MBOX_W-1:0] CODE_CONNECT    = 32'h2;
  localparam logic [MBOX_W-1:0] CODE_DISCONNECT = 32'h3;
  localparam logic [MBOX_W-1:0] CODE_CONSOLE    = 32'h5;
  localparam logic [MBOX_W-1:0] TX_FLAG         = 32'h8000_0000;

  localparam logic [CHAR_W-1:0] CHAR_LF = 8'h0A;
  localparam logic [CHAR_W-1:0] CHAR_CR = 8'h0D;

  localparam logic [1:0] ADDR_RX_MBOX = 2'd0;
  localparam logic [1:0] ADDR_TX_MBOX = 2'd1;
  localparam logic [1:0] ADDR_H2L_DB  = 2'd2;
  localparam logic [1:0] ADDR_L2H_DB  = 2'd3;

  // Strobes from the control engine to the datapath
  typedef struct packed {
    logic              pushChar;   // copy incoming mailbox byte into ring
    logic              flushRing;  // reset both ring pointers
    logic              clrRxMbox;  // zero the incoming mailbox
    logic              loadTx;     // post txChar into outgoing mailbox
    logic [CHAR_W-1:0] txChar;
    logic [MBOX_W-1:0] ringHost;   // bits to set in host-side doorbell
    logic [MBOX_W-1:0] ackLocal;   // bits to clear in incoming doorbell
  } dbmbStrobe_t;
endpackage

// File: rtl/dbmb_datapath.sv
module dbmb_datapath
  import dbmb_pkg::*;
#(
  parameter int                DEPTH          = 256,
  parameter logic [MBOX_W-1:0] HOST_IRQ_MASK  = '1,
  parameter logic [MBOX_W-1:0] LOCAL_IRQ_MASK = '1,
  localparam int               PTR_W          = $clog2(DEPTH),
  localparam int               USED_W         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [MBOX_W-1:0] hostWrData,
  output logic [MBOX_W-1:0] hostRdData,
  input  logic              rxReady,
  input  dbmbStrobe_t       stb,
  output logic              rxValid,
  output logic [CHAR_W-1:0] rxChar,
  output logic [USED_W-1:0] rxUsed,
  output logic              rxPop,
  output logic              txMboxEmpty,
  output logic [MBOX_W-1:0] rxMboxWord,
  output logic [MBOX_W-1:0] txMboxWord,
  output logic [MBOX_W-1:0] h2lWord,
  output logic [MBOX_W-1:0] l2hWord,
  output logic              hostIrq,
  output logic              localIrq
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [MBOX_W-1:0] rxMbox, txMbox, h2lDb, l2hDb;
  logic [CHAR_W-1:0] ring [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [USED_W-1:0] used;

  logic wrRx, wrTx, wrH2l, wrL2h;
  assign wrRx  = hostWrEn && (hostAddr == ADDR_RX_MBOX);
  assign wrTx  = hostWrEn && (hostAddr == ADDR_TX_MBOX);
  assign wrH2l = hostWrEn && (hostAddr == ADDR_H2L_DB);
  assign wrL2h = hostWrEn && (hostAddr == ADDR_L2H_DB);

  always_ff @(posedge clk) begin
    if (!rstN)              rxMbox <= '0;
    else if (wrRx)          rxMbox <= hostWrData;
    else if (stb.clrRxMbox) rxMbox <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           txMbox <= '0;
    else if (wrTx)       txMbox <= hostWrData;
    else if (stb.loadTx) txMbox <= TX_FLAG | MBOX_W'(stb.txChar);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      h2lDb <= '0;
      l2hDb <= '0;
    end else begin
      h2lDb <= (h2lDb & ~stb.ackLocal) | (wrH2l ? hostWrData : '0);
      l2hDb <= (l2hDb & ~(wrL2h ? hostWrData : '0)) | stb.ringHost;
    end
  end

  assign rxValid = (used != '0);
  assign rxPop   = rxValid && rxReady;

  always_ff @(posedge clk) begin
    if (stb.pushChar) ring[wrPtr] <= rxMbox[CHAR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.flushRing) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (stb.pushChar) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (rxPop)        rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      used <= used + USED_W'(stb.pushChar) - USED_W'(rxPop);
    end
  end

  assign rxChar      = ring[rdPtr];
  assign rxUsed      = used;
  assign txMboxEmpty = (txMbox == '0);
  assign hostIrq     = |(l2hDb & HOST_IRQ_MASK);
  assign localIrq    = |(h2lDb & LOCAL_IRQ_MASK);
  assign rxMboxWord  = rxMbox;
  assign txMboxWord  = txMbox;
  assign h2lWord     = h2lDb;
  assign l2hWord     = l2hDb;

  always_comb begin
    unique case (hostAddr)
      ADDR_RX_MBOX: hostRdData = rxMbox;
      ADDR_TX_MBOX: hostRdData = txMbox;
      ADDR_H2L_DB:  hostRdData = h2lDb;
      default:      hostRdData = l2hDb;
    endcase
  end
endmodule

// File: rtl/dbmb_control.sv
module dbmb_control
  import dbmb_pkg::*;
#(
  parameter int  DEPTH  = 256,
  parameter int  MARGIN = 4,
  localparam int USED_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              localIrq,
  input  logic [MBOX_W-1:0] h2lDb,
  input  logic [USED_W-1:0] rxUsed,
  input  logic              rxPop,
  input  logic              txMboxEmpty,
  input  logic              txValid,
  input  logic [CHAR_W-1:0] txChar,
  input  logic              dropLink,
  output dbmbStrobe_t       stb,
  output logic              txReady,
  output logic              linkUp,
  output logic              badCode,
  output logic              ringFull
);
  localparam logic [USED_W:0]   HIGH_MARK = (USED_W + 1)'(DEPTH - MARGIN);
  localparam logic [USED_W-1:0] CAPACITY  = USED_W'(DEPTH);

  logic isAlive, isConnect, isDisc, isData, isUnknown;
  logic pushNow, drainRelease, loadTx;
  logic [USED_W:0] usedAfter;
  logic txBusy;
  logic [CHAR_W-1:0] txHold;

  assign isAlive   = localIrq && (h2lDb == CODE_ALIVE);
  assign isConnect = localIrq && (h2lDb == CODE_CONNECT);
  assign isDisc    = localIrq && (h2lDb == CODE_DISCONNECT);
  assign isData    = localIrq && (h2lDb == CODE_CONSOLE);
  assign isUnknown = localIrq && !(isAlive || isConnect || isDisc || isData);

  always_comb begin
    pushNow      = isData && (rxUsed != CAPACITY);
    usedAfter    = {1'b0, rxUsed} + {{USED_W{1'b0}}, pushNow} - {{USED_W{1'b0}}, rxPop};
    drainRelease = !pushNow && rxPop && ringFull && (usedAfter < HIGH_MARK);
    loadTx       = txBusy && txMboxEmpty;

    stb           = '0;
    stb.pushChar  = pushNow;
    stb.flushRing = isConnect;
    stb.clrRxMbox = isConnect || (pushNow && (usedAfter <= HIGH_MARK)) || drainRelease;
    stb.loadTx    = loadTx;
    stb.txChar    = txHold;
    stb.ackLocal  = localIrq ? h2lDb : '0;
    stb.ringHost  = (isAlive  ? CODE_ALIVE      : '0)
                  | (dropLink ? CODE_DISCONNECT : '0)
                  | (loadTx   ? CODE_CONSOLE    : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ringFull <= 1'b0;
    else if (isConnect)    ringFull <= 1'b0;
    else if (pushNow)      ringFull <= (usedAfter > HIGH_MARK);
    else if (drainRelease) ringFull <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    linkUp <= 1'b0;
    else if (dropLink || isDisc)  linkUp <= 1'b0;
    else if (isConnect)           linkUp <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          badCode <= 1'b0;
    else if (isUnknown) badCode <= 1'b1;
  end

  assign txReady = !txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txHold <= '0;
    end else if (txValid && txReady) begin
      txBusy <= 1'b1;
      txHold <= txChar;
    end else if (loadTx) begin
      if (txHold == CHAR_LF) txHold <= CHAR_CR;
      else                   txBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/dbmb_console.sv
module dbmb_console
  import dbmb_pkg::*;
#(
  parameter int                DEPTH          = 256,
  parameter int                MARGIN         = 4,
  parameter logic [MBOX_W-1:0] HOST_IRQ_MASK  = '1,
  parameter logic [MBOX_W-1:0] LOCAL_IRQ_MASK = '1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        hostIrq,
  input  logic        txValid,
  input  logic [7:0]  txChar,
  output logic        txReady,
  output logic        rxValid,
  output logic [7:0]  rxChar,
  input  logic        rxReady,
  input  logic        dropLink,
  output logic        localIrq,
  output logic        linkUp,
  output logic        badCode
);
  localparam int USED_W = $clog2(DEPTH + 1);

  dbmbStrobe_t       stb;
  logic [USED_W-1:0] rxUsed;
  logic              rxPop, txMboxEmpty, ringFull;
  logic [MBOX_W-1:0] rxMboxWord, txMboxWord, h2lWord, l2hWord;

  dbmb_datapath #(
    .DEPTH(DEPTH), .HOST_IRQ_MASK(HOST_IRQ_MASK), .LOCAL_IRQ_MASK(LOCAL_IRQ_MASK)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .rxReady(rxReady), .stb(stb),
    .rxValid(rxValid), .rxChar(rxChar), .rxUsed(rxUsed), .rxPop(rxPop),
    .txMboxEmpty(txMboxEmpty),
    .rxMboxWord(rxMboxWord), .txMboxWord(txMboxWord), .h2lWord(h2lWord), .l2hWord(l2hWord),
    .hostIrq(hostIrq), .localIrq(localIrq)
  );

  dbmb_control #(.DEPTH(DEPTH), .MARGIN(MARGIN)) uCtl (
    .clk(clk), .rstN(rstN),
    .localIrq(localIrq), .h2lDb(h2lWord), .rxUsed(rxUsed), .rxPop(rxPop),
    .txMboxEmpty(txMboxEmpty), .txValid(txValid), .txChar(txChar), .dropLink(dropLink),
    .stb(stb), .txReady(txReady), .linkUp(linkUp), .badCode(badCode), .ringFull(ringFull)
  );
endmodule

module dbmb_console_chk
  import dbmb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [1:0]        hostAddr,
  input logic              localIrq,
  input logic              hostIrq,
  input logic              rxValid,
  input logic              linkUp,
  input logic              badCode,
  input logic              ringFull,
  input logic [MBOX_W-1:0] rxMbox,
  input logic [MBOX_W-1:0] txMbox,
  input logic [MBOX_W-1:0] h2lDb,
  input logic [MBOX_W-1:0] l2hDb
);
  // R2
  txFlag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMbox != '0 && $past(txMbox) == '0 && !$past(hostWrEn && hostAddr == ADDR_TX_MBOX))
      |-> txMbox[MBOX_W-1]);

  // R4
  aliveEcho_chk: assert property (@(posedge clk) disable iff (!rstN)
    (localIrq && h2lDb == CODE_ALIVE) |=> l2hDb[0]);

  // R5
  connect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (localIrq && h2lDb == CODE_CONNECT && !hostWrEn) |=> (linkUp && !rxValid && rxMbox == '0));

  // R7
  fullHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ringFull |-> (rxMbox != '0));

  // R9
  ackClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (localIrq && !(hostWrEn && hostAddr == ADDR_H2L_DB)) |=> (h2lDb == '0));

  // R10
  badSticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    badCode |=> badCode);

  // R11
  hostIrq_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (l2hDb != '0));
endmodule

bind dbmb_console dbmb_console_chk uChk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .localIrq(localIrq), .hostIrq(hostIrq), .rxValid(rxValid), .linkUp(linkUp),
  .badCode(badCode), .ringFull(ringFull), .rxMbox(rxMboxWord), .txMbox(txMboxWord),
  .h2lDb(h2lWord), .l2hDb(l2hWord)
);

// File: tb/tb_dbmb_console.sv
module tb_dbmb_console;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostIrq, txReady, rxValid, localIrq, linkUp, badCode;
  logic        txValid = 1'b0;
  logic [7:0]  txChar = '0;
  logic [7:0]  rxChar;
  logic        rxReady = 1'b0;
  logic        dropLink = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];

  always #4 clk = ~clk;

  dbmb_console dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostIrq(hostIrq),
    .txValid(txValid), .txChar(txChar), .txReady(txReady),
    .rxValid(rxValid), .rxChar(rxChar), .rxReady(rxReady),
    .dropLink(dropLink), .localIrq(localIrq), .linkUp(linkUp), .badCode(badCode)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  // ring an incoming doorbell code and wait until the engine has handled it
  task automatic hostRing(input logic [31:0] code);
    hostWrite(2'd2, code);
    @(negedge clk);
  endtask

  // driver: post a console byte from the host, expected byte into the scoreboard
  task automatic hostSend(input logic [7:0] c);
    hostWrite(2'd0, 32'h8000_0000 | {24'h0, c});
    rxQ.push_back(c);
    hostRing(32'h5);
  endtask

  // driver: local transmit, expected bytes into the scoreboard
  task automatic sendLocal(input logic [7:0] c);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txChar = c;
    @(negedge clk);
    txValid = 1'b0;
    txQ.push_back(c);
    if (c == 8'h0A) txQ.push_back(8'h0D);
  endtask

  // host-side consumer of the outgoing mailbox
  task automatic hostTake(input string tag);
    logic [31:0] d;
    logic [7:0]  e;
    d = '0;
    for (int i = 0; i < 20 && d == '0; i++) begin
      @(negedge clk);
      hostRead(2'd1, d);
    end
    e = (txQ.size() != 0) ? txQ.pop_front() : 8'hFF;
    checkEq(tag, d, 32'h8000_0000 | {24'h0, e});
    hostWrite(2'd1, 32'h0);
    hostWrite(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic popOne();
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
  endtask

  // monitor: compare popped receive bytes with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rxValid && rxReady) begin
        if (rxQ.size() == 0) checkEq("R6 unexpected rx byte", {24'h0, rxChar}, 32'hFFFF_FFFF);
        else checkEq("R6 rx order", {24'h0, rxChar}, {24'h0, rxQ.pop_front()});
      end
    end
  end

  initial begin
    #(8 * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      hostRead(2'(a), d);
      checkEq("R1 register reset", d, 32'h0);
    end
    checkEq("R1 txReady", {31'h0, txReady}, 32'h1);
    checkEq("R1 rxValid", {31'h0, rxValid}, 32'h0);
    checkEq("R1 irqs", {30'h0, hostIrq, localIrq}, 32'h0);
    checkEq("R1 status", {30'h0, linkUp, badCode}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R5 open session discards ring contents and pending mailbox
    hostSend(8'h11);
    hostSend(8'h22);
    checkEq("R6 stored", {31'h0, rxValid}, 32'h1);
    hostWrite(2'd0, 32'h8000_0077);
    hostWrite(2'd2, 32'h2);
    checkEq("R11 localIrq raised", {31'h0, localIrq}, 32'h1);
    hostRead(2'd2, d);
    checkEq("R9 incoming doorbell set", d, 32'h2);
    @(negedge clk);
    rxQ.delete();
    checkEq("R5 ring empty", {31'h0, rxValid}, 32'h0);
    hostRead(2'd0, d);
    checkEq("R5 mailbox zeroed", d, 32'h0);
    checkEq("R5 linkUp", {31'h0, linkUp}, 32'h1);
    hostRead(2'd2, d);
    checkEq("R9 incoming doorbell acked", d, 32'h0);
    checkEq("R11 localIrq low", {31'h0, localIrq}, 32'h0);

    // R6 several bytes in order
    rxReady = 1'b1;
    hostSend(8'h48);
    hostSend(8'h69);
    hostSend(8'h21);
    idle(3);
    rxReady = 1'b0;
    checkEq("R6 all bytes delivered", rxQ.size(), 32'h0);

    // R4 liveness echo
    hostRing(32'h1);
    hostRead(2'd3, d);
    checkEq("R4 alive echoed", d, 32'h1);
    checkEq("R11 hostIrq raised", {31'h0, hostIrq}, 32'h1);
    hostWrite(2'd3, 32'hFFFF_FFFF);
    hostRead(2'd3, d);
    checkEq("R9 host doorbell w1c", d, 32'h0);
    checkEq("R11 hostIrq cleared", {31'h0, hostIrq}, 32'h0);

    // R2 transmit and hold while mailbox occupied
    sendLocal(8'h41);
    @(negedge clk);
    hostRead(2'd1, d);
    checkEq("R2 tx word", d, 32'h8000_0041);
    hostRead(2'd3, d);
    checkEq("R2 data code rung", d, 32'h5);
    sendLocal(8'h42);
    idle(5);
    hostRead(2'd1, d);
    checkEq("R2 held while occupied", d, 32'h8000_0041);
    checkEq("R2 txReady low while holding", {31'h0, txReady}, 32'h0);
    hostTake("R2 first byte");
    hostTake("R2 second byte");

    // R3 line feed followed by carriage return
    sendLocal(8'h0A);
    hostTake("R3 line feed");
    hostTake("R3 carriage return");
    sendLocal(8'h78);
    hostTake("R3 next byte after CR");

    // R10 unknown code
    hostWrite(2'd0, 32'h8000_0055);
    hostRing(32'h7);
    checkEq("R10 badCode set", {31'h0, badCode}, 32'h1);
    hostRead(2'd0, d);
    checkEq("R10 mailbox untouched", d, 32'h8000_0055);
    checkEq("R10 no ring write", {31'h0, rxValid}, 32'h0);
    hostRead(2'd3, d);
    checkEq("R10 no outgoing doorbell", d, 32'h0);
    hostRead(2'd2, d);
    checkEq("R10 doorbell acked", d, 32'h0);
    hostWrite(2'd0, 32'h0);

    // R7 / R8 flow control
    hostRing(32'h2);
    for (int i = 0; i < 252; i++) hostSend(8'(i));
    hostRead(2'd0, d);
    checkEq("R7 mailbox cleared at mark", d, 32'h0);
    hostSend(8'hFC);
    hostRead(2'd0, d);
    checkEq("R7 mailbox kept above mark", d, 32'h8000_00FC);
    popOne();
    hostRead(2'd0, d);
    checkEq("R8 still held at mark", d, 32'h8000_00FC);
    popOne();
    hostRead(2'd0, d);
    checkEq("R8 released below mark", d, 32'h0);
    rxReady = 1'b1;
    idle(260);
    rxReady = 1'b0;
    checkEq("R8 ring drained", rxQ.size(), 32'h0);
    checkEq("R8 rxValid low", {31'h0, rxValid}, 32'h0);

    // R12 disconnect in both directions
    hostWrite(2'd3, 32'hFFFF_FFFF);
    @(negedge clk); dropLink = 1'b1;
    @(negedge clk); dropLink = 1'b0;
    hostRead(2'd3, d);
    checkEq("R12 disconnect rung", d, 32'h3);
    checkEq("R12 linkUp cleared", {31'h0, linkUp}, 32'h0);
    hostRing(32'h2);
    checkEq("R12 reopened", {31'h0, linkUp}, 32'h1);
    hostRing(32'h3);
    checkEq("R12 host disconnect", {31'h0, linkUp}, 32'h0);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule